// File: doc/BRIEF.md
# Packet-to-Backplane Bus Access Bridge

This block sits between a packet-side register request interface and a 16-bit parallel backplane bus. Every request carries a 16-bit byte address, a byte length, a direction and (for writes) a 16-bit word. A well-formed request becomes exactly one bus cycle, whose 4-bit function code and 11-bit sub-address both come from the request address. The direction supplies the top function bit. Malformed requests are answered with an error and never reach the bus.

The bridge records each finished cycle in a small bank of readable status bytes:
- the most recent read word and the most recent write word;
- the function code and sub-address of the last cycle;
- a flag nibble holding the Q and acknowledge responses and a collision mark.

A cycle is refused, without touching the bus, when a local FIFO read is in progress as it is accepted. A target that never answers is cut off after a fixed number of cycles. A command write can flush the bridge and pulse a FIFO clear, but only while the packet-start enable bit of the control register is set.

Top module: `pkt_bus_bridge`

## Requirements
- R1: A request is well formed only if address bit 15 is 1, address bit 0 is 0 and the length is exactly 2 bytes. Any other request returns `rsp_valid` with `rsp_err`=1 on the cycle after it is presented. It drives no bus strobe and changes no status byte.
- R2: For a well-formed request, `bus_fn[2:0]` equals address bits 14-12 and `bus_sa` equals address bits 11-1. Both are held for the whole strobe.
- R3: `bus_fn[3]` is 1 for a write and 0 for a read.
- R4: `busy` is high from the cycle after acceptance until the cycle ends. Requests presented while busy are ignored: they get no response and do not change the bus fields.
- R5: A write drives its word on `bus_wdata`. Once the cycle ends, status bytes 2 (low) and 3 (high) hold that word.
- R6: On a read answered by the target, `bus_rdata` is returned on `rsp_rdata`. It is also stored in status bytes 0 (low) and 1 (high). A read that times out leaves bytes 0 and 1 unchanged and returns 0.
- R7: Status byte 4 holds the last function code in bits 7-4, 0 in bit 3 and sub-address bits 10-8 in bits 2-0. Status byte 5 holds sub-address bits 7-0.
- R8: When a cycle ends, status byte 6 bit 0 takes the target's Q response and bit 1 takes its acknowledge response. Bit 3 reads 0.
- R9: If `fifo_rd_busy` is high when a well-formed request is accepted, no strobe is driven. `rsp_valid` follows on the next cycle with `rsp_err`=0. Byte 6 bits 2-0 become 100, and bytes 4 and 5 record the refused function and sub-address.
- R10: If the target does not raise `bus_done` within TIMEOUT_CYC strobe cycles (default 16), the strobe drops after exactly that many cycles. The cycle then ends with byte 6 bits 2-0 equal to 000.
- R11: A command write with bit 2 set is a soft reset, but only while control bit 6 is 1. It ends any cycle at once (strobe and busy low on the next cycle) and clears byte 6 bits 2-0. It also pulses `fifo_clr` for one cycle. With control bit 6 at 0, the command has no effect.
- R12: Control bits 6-4 are written through `ctrl_we` and read back in byte 6 bits 6-4. Byte 6 bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request byte address |
| req_len | input | 8 | Request data length in bytes |
| req_wdata | input | 16 | Write word |
| busy | output | 1 | Bus cycle in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is a malformed-request error |
| rsp_rdata | output | 16 | Read word returned |
| bus_strobe | output | 1 | Bus cycle active |
| bus_fn | output | 4 | Bus function code |
| bus_sa | output | 11 | Bus sub-address |
| bus_wdata | output | 16 | Bus write word |
| bus_done | input | 1 | Target ends the cycle |
| bus_rdata | input | 16 | Target read word |
| bus_q | input | 1 | Target Q response |
| bus_ack | input | 1 | Target acknowledge response |
| fifo_rd_busy | input | 1 | Local FIFO read in progress |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| cmd_we | input | 1 | Command register write |
| cmd_wdata | input | 8 | Command byte |
| ctrl_we | input | 1 | Control register write |
| ctrl_wdata | input | 8 | Control byte |
| stat_addr | input | 3 | Status byte select |
| stat_rdata | output | 8 | Selected status byte |

## Verification
Writes and reads go to addresses chosen so that every function bit and the high and low sub-address bits differ. This separates a swapped or shifted field and a wrongly forced top function bit. The target answers after different delays and with different Q and acknowledge combinations, which shows that the flags follow the response rather than the direction. Three malformed requests each break a different rule (top bit clear, odd address, wrong length), so the check on each rule stands alone. A silent target, a busy FIFO, a second request arriving during a cycle, and a soft reset tried with its enable off and then on cover the paths that end a cycle without a normal answer.

// File: rtl/pbb_pkg.sv
// Shared types of the packet-to-backplane bridge.
// Assumes a 4-bit function code and an 11-bit sub-address on the bus.
package pbb_pkg;
    localparam int FN_W = 4;
    localparam int SA_W = 11;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_CYCLE = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic [FN_W-1:0] fn;
        logic [SA_W-1:0] sa;
    } bus_cmd_t;
endpackage

// File: rtl/pbb_addr_decode.sv
// Request address decoder.
// Checks that a request is well formed and splits its address into a bus
// function code and a sub-address. Purely combinational. Assumes ADDR_W is
// at least SA_W + FN_W + 1.
module pbb_addr_decode
    import pbb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 8,
    parameter int ACCESS_LEN = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              write,
    output logic              ok,
    output bus_cmd_t          cmd
);
    localparam int FN_LO = ADDR_W - FN_W;

    // Well-formed check: top address bit set, even address, exact length.
    always_comb begin
        ok = addr[ADDR_W-1] && !addr[0] && (len == LEN_W'(ACCESS_LEN));
    end

    // Field split: the direction supplies the top function bit.
    always_comb begin
        cmd.fn = {write, addr[ADDR_W-2:FN_LO]};
        cmd.sa = addr[SA_W:1];
    end
endmodule

// File: rtl/pbb_cycle_seq.sv
// Bus cycle sequencer.
// Accepts one request at a time and either refuses it (FIFO collision),
// answers it with an error (malformed), or runs one strobe on the bus
// until the target answers or the timeout expires. Emits a one-cycle
// "finish" bundle for the status bank. A soft reset drops any cycle at
// once. Assumes TIMEOUT_CYC >= 1.
module pbb_cycle_seq
    import pbb_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int TIMEOUT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              req_valid,
    input  logic              req_ok,
    input  bus_cmd_t          req_cmd,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              fifo_rd_busy,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_q,
    input  logic              bus_ack,
    output logic              busy,
    output logic              bus_strobe,
    output bus_cmd_t          bus_cmd,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              fin,
    output bus_cmd_t          fin_cmd,
    output logic              fin_col,
    output logic              fin_q,
    output logic              fin_ack,
    output logic              fin_rd_upd,
    output logic              fin_wr_upd
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    seq_state_t        state_q;
    logic [TW-1:0]     tmr_q;
    logic              accept, go_now, col_now, bad_now, done_now, tmo_now;
    logic              cur_write;

    assign cur_write = bus_cmd.fn[FN_W-1];

    // Event decode for the current cycle.
    always_comb begin
        accept   = (state_q == ST_IDLE) && req_valid && !soft_rst;
        go_now   = accept && req_ok && !fifo_rd_busy;
        col_now  = accept && req_ok && fifo_rd_busy;
        bad_now  = accept && !req_ok;
        done_now = (state_q == ST_CYCLE) && bus_done && !soft_rst;
        tmo_now  = (state_q == ST_CYCLE) && !bus_done && !soft_rst
                   && (tmr_q == TW'(TIMEOUT_CYC - 1));
    end

    // Finish bundle toward the status bank.
    always_comb begin
        fin        = col_now || done_now || tmo_now;
        fin_cmd    = col_now ? req_cmd : bus_cmd;
        fin_col    = col_now;
        fin_q      = done_now && bus_q;
        fin_ack    = done_now && bus_ack;
        fin_rd_upd = done_now && !cur_write;
        fin_wr_upd = (done_now || tmo_now) && cur_write;
    end

    assign busy       = (state_q == ST_CYCLE);
    assign bus_strobe = (state_q == ST_CYCLE);

    // State, timer and latched bus fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tmr_q     <= '0;
            bus_cmd   <= '0;
            bus_wdata <= '0;
        end else if (soft_rst) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
        end else if (go_now) begin
            state_q   <= ST_CYCLE;
            tmr_q     <= '0;
            bus_cmd   <= req_cmd;
            bus_wdata <= req_wdata;
        end else if (done_now || tmo_now) begin
            state_q <= ST_IDLE;
        end else if (state_q == ST_CYCLE) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // Registered response toward the packet side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= fin || bad_now;
            rsp_err   <= bad_now;
            rsp_rdata <= (done_now && !cur_write) ? bus_rdata : '0;
        end
    end
endmodule

// File: rtl/pbb_status_regs.sv
// Status and control byte bank.
// Holds the last read and write words, the last function/sub-address, the
// response flags and the control bits, and exposes them as bytes.
// Byte map: read word, then write word (low byte first), then function/
// sub-address high, sub-address low, control+flags. Assumes SA_W = 11.
module pbb_status_regs
    import pbb_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int STAT_AW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr,
    input  logic               fin,
    input  bus_cmd_t           fin_cmd,
    input  logic               fin_col,
    input  logic               fin_q,
    input  logic               fin_ack,
    input  logic               fin_rd_upd,
    input  logic               fin_wr_upd,
    input  logic [DATA_W-1:0]  rdata,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               ctrl_we,
    input  logic [7:0]         ctrl_wdata,
    input  logic [STAT_AW-1:0] stat_addr,
    output logic [7:0]         stat_rdata,
    output logic               start_en
);
    localparam int NB       = DATA_W / 8;
    localparam int OFS_WR   = NB;
    localparam int OFS_CMD  = 2 * NB;
    localparam int OFS_SA   = 2 * NB + 1;
    localparam int OFS_FLG  = 2 * NB + 2;
    localparam int NREG     = 2 * NB + 3;

    logic [DATA_W-1:0] rd_q, wr_q;
    bus_cmd_t          cmd_q;
    logic [2:0]        flg_q;
    logic [2:0]        ctl_q;
    logic [7:0]        bytes_w [NREG];

    // Capture of last-cycle data, fields, flags and control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cmd_q <= '0;
            flg_q <= '0;
            ctl_q <= '0;
        end else begin
            if (soft_clr)      flg_q <= '0;
            else if (fin)      flg_q <= {fin_col, fin_ack, fin_q};
            if (fin)           cmd_q <= fin_cmd;
            if (fin_rd_upd)    rd_q  <= rdata;
            if (fin_wr_upd)    wr_q  <= wdata;
            if (ctrl_we)       ctl_q <= ctrl_wdata[6:4];
        end
    end

    // Byte lanes of the two data words.
    for (genvar l = 0; l < NB; l++) begin : g_lane
        assign bytes_w[l]          = rd_q[8*l +: 8];
        assign bytes_w[OFS_WR + l] = wr_q[8*l +: 8];
    end
    assign bytes_w[OFS_CMD] = {cmd_q.fn, 1'b0, cmd_q.sa[SA_W-1:8]};
    assign bytes_w[OFS_SA]  = cmd_q.sa[7:0];
    assign bytes_w[OFS_FLG] = {1'b0, ctl_q, 1'b0, flg_q};

    // Read multiplexer; unused selects read 0.
    always_comb begin
        stat_rdata = 8'h00;
        if (int'(stat_addr) < NREG) stat_rdata = bytes_w[stat_addr];
    end

    assign start_en = ctl_q[2];
endmodule

// File: rtl/pkt_bus_bridge.sv
// Packet-to-backplane bus access bridge (top).
// Decodes requests, runs one bus cycle per well-formed request, keeps the
// status bank and gates the soft reset command with the start-enable bit.
// Assumes requests are held for one cycle and the target answers with a
// one-cycle bus_done pulse.
module pkt_bus_bridge
    import pbb_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int LEN_W       = 8,
    parameter int DATA_W      = 16,
    parameter int ACCESS_LEN  = 2,
    parameter int TIMEOUT_CYC = 16,
    parameter int STAT_AW     = $clog2(2 * (DATA_W / 8) + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               busy,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               bus_strobe,
    output logic [FN_W-1:0]    bus_fn,
    output logic [SA_W-1:0]    bus_sa,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_done,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_q,
    input  logic               bus_ack,
    input  logic               fifo_rd_busy,
    output logic               fifo_clr,
    input  logic               cmd_we,
    input  logic [7:0]         cmd_wdata,
    input  logic               ctrl_we,
    input  logic [7:0]         ctrl_wdata,
    input  logic [STAT_AW-1:0] stat_addr,
    output logic [7:0]         stat_rdata
);
    logic     dec_ok, start_en, soft_rst;
    bus_cmd_t dec_cmd, cur_cmd, fin_cmd;
    logic     fin, fin_col, fin_q, fin_ack, fin_rd_upd, fin_wr_upd;

    // Soft reset only counts while the start-enable control bit is set.
    assign soft_rst = cmd_we && cmd_wdata[2] && start_en;

    pbb_addr_decode #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ACCESS_LEN(ACCESS_LEN)
    ) dec_i (
        .addr(req_addr), .len(req_len), .write(req_write),
        .ok(dec_ok), .cmd(dec_cmd)
    );

    pbb_cycle_seq #(
        .DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .req_valid(req_valid), .req_ok(dec_ok), .req_cmd(dec_cmd),
        .req_wdata(req_wdata), .fifo_rd_busy(fifo_rd_busy),
        .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_q(bus_q),
        .bus_ack(bus_ack), .busy(busy), .bus_strobe(bus_strobe),
        .bus_cmd(cur_cmd), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .fin(fin),
        .fin_cmd(fin_cmd), .fin_col(fin_col), .fin_q(fin_q),
        .fin_ack(fin_ack), .fin_rd_upd(fin_rd_upd), .fin_wr_upd(fin_wr_upd)
    );

    pbb_status_regs #(
        .DATA_W(DATA_W), .STAT_AW(STAT_AW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst), .fin(fin),
        .fin_cmd(fin_cmd), .fin_col(fin_col), .fin_q(fin_q),
        .fin_ack(fin_ack), .fin_rd_upd(fin_rd_upd), .fin_wr_upd(fin_wr_upd),
        .rdata(bus_rdata), .wdata(bus_wdata), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .stat_addr(stat_addr),
        .stat_rdata(stat_rdata), .start_en(start_en)
    );

    assign bus_fn = cur_cmd.fn;
    assign bus_sa = cur_cmd.sa;

    // One-cycle FIFO clear pulse on an accepted soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_clr <= 1'b0;
        else        fifo_clr <= soft_rst;
    end
endmodule

// File: rtl/pbb_checker.sv
// Assertion checker for the bridge, bound to every pkt_bus_bridge instance.
// Works on the top-level ports only.
module pbb_checker #(
    parameter int ADDR_W      = 16,
    parameter int LEN_W       = 8,
    parameter int DATA_W      = 16,
    parameter int TIMEOUT_CYC = 16,
    parameter int STAT_AW     = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [LEN_W-1:0]   req_len,
    input logic               busy,
    input logic               rsp_err,
    input logic               bus_strobe,
    input logic [3:0]         bus_fn,
    input logic [10:0]        bus_sa,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               fifo_rd_busy,
    input logic               cmd_we,
    input logic [7:0]         cmd_wdata,
    input logic [STAT_AW-1:0] stat_addr,
    input logic [7:0]         stat_rdata
);
    localparam int CW = $clog2(TIMEOUT_CYC + 2);

    logic          req_good, cmd_quiet;
    logic [CW-1:0] strobe_cnt;

    assign req_good  = req_addr[ADDR_W-1] && !req_addr[0] && (req_len == LEN_W'(2));
    assign cmd_quiet = !(cmd_we && cmd_wdata[2]);

    // Count consecutive strobe cycles for the timeout bound.
    always_ff @(posedge clk) begin
        if (!rst_n)          strobe_cnt <= '0;
        else if (bus_strobe) strobe_cnt <= strobe_cnt + 1'b1;
        else                 strobe_cnt <= '0;
    end

    AST_BAD_REQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_good && cmd_quiet) |=> (rsp_err && !bus_strobe)); // R1
    AST_SA_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_strobe) |-> (bus_sa == $past(req_addr[11:1])
                               && bus_fn[2:0] == $past(req_addr[14:12]))); // R2
    AST_FN_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_strobe) |-> (bus_fn[3] == $past(req_write))); // R3
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> busy); // R4
    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && $past(bus_strobe)) |-> ($stable(bus_fn) && $stable(bus_sa)
                                              && $stable(bus_wdata))); // R4
    AST_COLLISION_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_good && fifo_rd_busy && cmd_quiet) |=> !bus_strobe); // R9
    AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |-> (int'(strobe_cnt) < TIMEOUT_CYC)); // R10
    AST_FLAG_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_addr == STAT_AW'(6)) |-> (!stat_rdata[7] && !stat_rdata[3])); // R12
endmodule

bind pkt_bus_bridge pbb_checker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
    .TIMEOUT_CYC(TIMEOUT_CYC), .STAT_AW(STAT_AW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .rsp_err(rsp_err),
    .bus_strobe(bus_strobe), .bus_fn(bus_fn), .bus_sa(bus_sa),
    .bus_wdata(bus_wdata), .fifo_rd_busy(fifo_rd_busy), .cmd_we(cmd_we),
    .cmd_wdata(cmd_wdata), .stat_addr(stat_addr), .stat_rdata(stat_rdata)
);

// File: tb/pkt_bus_bridge_tb_top.sv
// Directed bench for the bridge: one task per scenario, each checking itself.
module pkt_bus_bridge_tb_top;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, rsp_valid, rsp_err;
    logic [15:0] rsp_rdata;
    logic        bus_strobe;
    logic [3:0]  bus_fn;
    logic [10:0] bus_sa;
    logic [15:0] bus_wdata;
    logic        bus_done = 1'b0;
    logic [15:0] bus_rdata = '0;
    logic        bus_q = 1'b0, bus_ack = 1'b0;
    logic        fifo_rd_busy = 1'b0;
    logic        fifo_clr;
    logic        cmd_we = 1'b0, ctrl_we = 1'b0;
    logic [7:0]  cmd_wdata = '0, ctrl_wdata = '0;
    logic [2:0]  stat_addr = '0;
    logic [7:0]  stat_rdata;

    int checks = 0, errors = 0;
    bit finished = 0;

    // Target model state.
    bit          tgt_silent = 0;
    int          tgt_delay = 0, tgt_wait = 0;
    logic [15:0] tgt_word = '0;
    logic        tgt_q = 1'b0, tgt_ack = 1'b0;
    logic [3:0]  seen_fn = '0;
    logic [10:0] seen_sa = '0;
    logic [15:0] seen_wd = '0;

    always #2.5 clk = ~clk;

    pkt_bus_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .bus_strobe(bus_strobe), .bus_fn(bus_fn),
        .bus_sa(bus_sa), .bus_wdata(bus_wdata), .bus_done(bus_done),
        .bus_rdata(bus_rdata), .bus_q(bus_q), .bus_ack(bus_ack),
        .fifo_rd_busy(fifo_rd_busy), .fifo_clr(fifo_clr), .cmd_we(cmd_we),
        .cmd_wdata(cmd_wdata), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .stat_addr(stat_addr), .stat_rdata(stat_rdata)
    );

    // Target: answers a strobe after tgt_delay further cycles, on the falling edge.
    always @(negedge clk) begin
        if (bus_strobe && !tgt_silent && !bus_done) begin
            if (tgt_wait == tgt_delay) begin
                bus_done  <= 1'b1;
                bus_rdata <= tgt_word;
                bus_q     <= tgt_q;
                bus_ack   <= tgt_ack;
                seen_fn   <= bus_fn;
                seen_sa   <= bus_sa;
                seen_wd   <= bus_wdata;
            end else begin
                tgt_wait <= tgt_wait + 1;
            end
        end else begin
            bus_done <= 1'b0;
            tgt_wait <= 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd_stat(input int a, output logic [7:0] v);
        stat_addr = 3'(a);
        #1;
        v = stat_rdata;
    endtask

    // Present one request for a cycle, then follow it to its response.
    task automatic do_req(input logic w, input logic [15:0] a, input logic [7:0] l,
                          input logic [15:0] d, output int strobes,
                          output logic err, output logic [15:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_len = l; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        strobes = 0;
        for (int i = 0; i < 100 && !rsp_valid; i++) begin
            if (bus_strobe) strobes++;
            @(negedge clk);
        end
        err = rsp_err;
        rd  = rsp_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R4 busy after reset", busy, 0);
        chk("R4 strobe after reset", bus_strobe, 0);
        chk("R1 rsp_valid after reset", rsp_valid, 0);
        for (int i = 0; i < 7; i++) begin
            rd_stat(i, v);
            chk("R7 status byte reset", v, 0);
        end
    endtask

    task automatic t_write();
        int n; logic e; logic [15:0] r; logic [7:0] v;
        tgt_delay = 2; tgt_q = 1; tgt_ack = 1; tgt_word = 16'h0;
        do_req(1'b1, 16'hB3C4, 8'd2, 16'h1234, n, e, r);
        chk("R4 strobe length on write", n, 3);
        chk("R1 write err", e, 0);
        chk("R3 write fn seen", seen_fn, 4'hB);
        chk("R2 write sa seen", seen_sa, 11'h1E2);
        chk("R5 write word on bus", seen_wd, 16'h1234);
        rd_stat(2, v); chk("R5 write low byte", v, 8'h34);
        rd_stat(3, v); chk("R5 write high byte", v, 8'h12);
        rd_stat(4, v); chk("R7 fn/sa-high byte", v, 8'hB1);
        rd_stat(5, v); chk("R7 sa-low byte", v, 8'hE2);
        rd_stat(6, v); chk("R8 flags q+ack", v, 8'h03);
    endtask

    task automatic t_read();
        int n; logic e; logic [15:0] r; logic [7:0] v;
        tgt_delay = 0; tgt_q = 1; tgt_ack = 0; tgt_word = 16'hBEEF;
        do_req(1'b0, 16'hF00A, 8'd2, 16'h0, n, e, r);
        chk("R3 read fn seen", seen_fn, 4'h7);
        chk("R2 read sa seen", seen_sa, 11'h005);
        chk("R6 read response word", r, 16'hBEEF);
        rd_stat(0, v); chk("R6 read low byte", v, 8'hEF);
        rd_stat(1, v); chk("R6 read high byte", v, 8'hBE);
        rd_stat(4, v); chk("R7 fn/sa-high byte read", v, 8'h70);
        rd_stat(5, v); chk("R7 sa-low byte read", v, 8'h05);
        rd_stat(6, v); chk("R8 flags q only", v, 8'h01);
    endtask

    task automatic t_bad();
        int n; logic e; logic [15:0] r; logic [7:0] v;
        do_req(1'b0, 16'h7000, 8'd2, 16'h0, n, e, r);
        chk("R1 top bit clear err", e, 1); chk("R1 top bit clear no strobe", n, 0);
        do_req(1'b1, 16'h8001, 8'd2, 16'h5555, n, e, r);
        chk("R1 odd address err", e, 1); chk("R1 odd address no strobe", n, 0);
        do_req(1'b0, 16'h8002, 8'd4, 16'h0, n, e, r);
        chk("R1 bad length err", e, 1); chk("R1 bad length no strobe", n, 0);
        rd_stat(5, v); chk("R1 status unchanged", v, 8'h05);
        rd_stat(2, v); chk("R1 write word unchanged", v, 8'h34);
    endtask

    task automatic t_busy_ignore();
        int rsps = 0; logic [7:0] v;
        tgt_delay = 4; tgt_q = 0; tgt_ack = 1;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 16'h9246; req_len = 2; req_wdata = 16'hA0A0;
        @(negedge clk);
        req_addr = 16'hC888; req_wdata = 16'h0F0F;
        chk("R4 busy during cycle", busy, 1);
        @(negedge clk);
        req_valid = 0;
        chk("R4 sa held while busy", bus_sa, 11'h123);
        for (int i = 0; i < 20; i++) begin
            if (rsp_valid) rsps++;
            @(negedge clk);
        end
        chk("R4 one response only", rsps, 1);
        chk("R4 target saw first sa", seen_sa, 11'h123);
        rd_stat(3, v); chk("R5 first word kept", v, 8'hA0);
        rd_stat(6, v); chk("R8 flags ack only", v, 8'h02);
    endtask

    task automatic t_collision();
        int n; logic e; logic [15:0] r; logic [7:0] v;
        fifo_rd_busy = 1;
        do_req(1'b0, 16'hD554, 8'd2, 16'h0, n, e, r);
        fifo_rd_busy = 0;
        chk("R9 no strobe on collision", n, 0);
        chk("R9 err clear on collision", e, 0);
        rd_stat(6, v); chk("R9 collision flag", v, 8'h04);
        rd_stat(4, v); chk("R9 refused fn/sa", v, 8'h52);
        rd_stat(5, v); chk("R9 refused sa low", v, 8'hAA);
    endtask

    task automatic t_timeout();
        int n; logic e; logic [15:0] r; logic [7:0] v;
        tgt_silent = 1;
        do_req(1'b0, 16'h8002, 8'd2, 16'h0, n, e, r);
        tgt_silent = 0;
        chk("R10 strobe cycles at timeout", n, TMO);
        chk("R6 timeout returns zero", r, 0);
        rd_stat(6, v); chk("R10 flags cleared", v, 8'h00);
        rd_stat(0, v); chk("R6 read low kept", v, 8'hEF);
        rd_stat(5, v); chk("R7 timeout sa low", v, 8'h01);
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk); ctrl_we = 1; ctrl_wdata = d;
        @(negedge clk); ctrl_we = 0;
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        wr_ctrl(8'hFF);
        rd_stat(6, v); chk("R12 control bits set", v, 8'h74);
        wr_ctrl(8'h00);
        rd_stat(6, v); chk("R12 control bits clear", v, 8'h04);
    endtask

    task automatic t_soft_off();
        logic [7:0] v; int pulses = 0;
        @(negedge clk); cmd_we = 1; cmd_wdata = 8'h04;
        @(negedge clk); cmd_we = 0;
        if (fifo_clr) pulses++;
        @(negedge clk);
        if (fifo_clr) pulses++;
        chk("R11 no clear when disabled", pulses, 0);
        rd_stat(6, v); chk("R11 flags kept when disabled", v, 8'h04);
    endtask

    task automatic t_soft_on();
        logic [7:0] v;
        wr_ctrl(8'h40);
        tgt_silent = 1;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 16'h8010; req_len = 2;
        @(negedge clk);
        req_valid = 0;
        chk("R4 busy before soft reset", busy, 1);
        cmd_we = 1; cmd_wdata = 8'h04;
        @(negedge clk);
        cmd_we = 0;
        chk("R11 busy dropped", busy, 0);
        chk("R11 strobe dropped", bus_strobe, 0);
        chk("R11 fifo clear pulse", fifo_clr, 1);
        rd_stat(6, v); chk("R11 flags cleared", v, 8'h40);
        @(negedge clk);
        chk("R11 clear pulse one cycle", fifo_clr, 0);
        chk("R11 no response after abort", rsp_valid, 0);
        tgt_silent = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_bad();
        t_busy_ignore();
        t_timeout();
        t_collision();
        t_ctrl();
        t_soft_off();
        t_soft_on();
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule